// File: doc/BRIEF.md
# Integer Status Flags and Branch Condition Unit

This block sits beside an integer execution unit. Each cycle an operation class, a source operand and a destination operand arrive with a width selector. The block forms the integer result, tells the register file whether that result is to be written, and derives five status flags from it. The flags are captured in a small state register.

A separate combinational port evaluates a branch or conditional-move condition against that stored state. It takes only a condition selector, with no operands. Compare and test operations exist purely to set flags and never request a write. Equality conditions look at the zero flag alone, so a decrementing loop counter can close its loop without an explicit compare.

Width selection lets one datapath serve byte, half-word, word and double-word operations. Carry, sign and overflow are taken at the most significant bit of the chosen width.

Top module: `alu_status_unit`

## Requirements
- R1: `op_kind` encodes 0 add, 1 subtract, 2 decrement, 3 AND, 4 OR, 5 XOR, 6 test, 7 compare. `result_we` is 1 exactly when `op_valid` is 1 and the operation is one of codes 0 to 5.
- R2: Subtract and compare compute `dst_b` minus `src_a`. Decrement computes `dst_b` minus one. No operation computes the reverse difference.
- R3: Test forms `dst_b & src_a` and compare forms the difference. Both set the flags from that value and hold `result_we` at 0.
- R4: The carry flag is the carry out of the top bit of the selected width for add, and the borrow out of it for subtract and compare. Decrement leaves the carry flag unchanged.
- R5: The zero flag is 1 when the width-masked result is all zeros. The sign flag copies the top bit of the selected width. The parity flag is the XOR of all result bits within the width, so it is 1 when the count of ones is odd.
- R6: The overflow flag is 1 on signed overflow. For add, that means both operands have the same sign and the result sign differs from it. For subtract and compare, it means the operand signs differ and the result sign differs from `dst_b`. For decrement, it means `dst_b` equals the most negative value.
- R7: AND, OR, XOR and test clear both the carry flag and the overflow flag.
- R8: `width_sel` codes 0, 1, 2, 3 select 8, 16, 32 and 64 bits. Codes wider than XLEN fall back to XLEN. Bits of `result` above the selected width are 0.
- R9: `flags_out` bit positions are: 0 carry, 1 parity, 2 zero, 3 sign, 4 overflow. The register resets to all zeros. It updates on the clock edge when `op_valid` is 1 and `op_kind` is 0 to 7. Otherwise it holds, and that includes the reserved codes 8 to 15.
- R10: `cond_sel` encodes these conditions:
  - 2 signed-less: S^O
  - 3 signed-greater-or-equal: its inverse
  - 4 signed-less-or-equal: (S^O)|Z
  - 5 signed-greater: its inverse
  - 6 below: C
  - 7 above-or-equal: its inverse
  - 8 below-or-equal: C|Z
  - 9 above: its inverse
  - 10 to 15: never taken
- R11: `cond_sel` 0 (equal) returns the zero flag and 1 (not-equal) returns its inverse. Neither reads any other flag, so a not-equal branch after a decrement is taken until the counter reaches zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_kind | input | 4 | Operation class code |
| width_sel | input | 2 | Operand width code |
| src_a | input | XLEN | Source operand |
| dst_b | input | XLEN | Destination operand (minuend) |
| result | output | XLEN | Width-masked integer result |
| result_we | output | 1 | Register write request |
| flags_out | output | 5 | Stored status flags |
| cond_sel | input | 4 | Condition selector |
| cond_taken | output | 1 | Condition outcome from stored flags |

## Verification
The hardest state to reach from the ports is a flag set that separates the signed and unsigned conditions. One example is a compare where the destination is unsigned-above but signed-less. Another is a decrement that must preserve an earlier carry while it sets zero. The stimulus sets up these states on purpose. An 8-bit compare of 0x80 against 0x01 splits the signed and unsigned conditions. An add that produces a carry is followed by a decrement loop counting down to zero. After each step every condition selector is swept against flags predicted in the bench.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

   localparam logic [3:0] OPK_ADD  = 4'd0;
   localparam logic [3:0] OPK_SUB  = 4'd1;
   localparam logic [3:0] OPK_DEC  = 4'd2;
   localparam logic [3:0] OPK_AND  = 4'd3;
   localparam logic [3:0] OPK_OR   = 4'd4;
   localparam logic [3:0] OPK_XOR  = 4'd5;
   localparam logic [3:0] OPK_TEST = 4'd6;
   localparam logic [3:0] OPK_CMP  = 4'd7;

   localparam logic [3:0] CND_EQ = 4'd0;
   localparam logic [3:0] CND_NE = 4'd1;
   localparam logic [3:0] CND_LT = 4'd2;
   localparam logic [3:0] CND_GE = 4'd3;
   localparam logic [3:0] CND_LE = 4'd4;
   localparam logic [3:0] CND_GT = 4'd5;
   localparam logic [3:0] CND_B  = 4'd6;
   localparam logic [3:0] CND_AE = 4'd7;
   localparam logic [3:0] CND_BE = 4'd8;
   localparam logic [3:0] CND_A  = 4'd9;

   typedef struct packed {
      logic ovf;
      logic sgn;
      logic zro;
      logic par;
      logic cry;
   } flag_s;

endpackage

// File: rtl/alu_flag_lane.sv
module alu_flag_lane
   import alu_flag_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [3:0]   op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] res,
   output logic         cry,
   output logic         ovf,
   output logic         zro,
   output logic         sgn,
   output logic         par
);
   logic [W:0]   sum_w;
   logic [W:0]   dif_w;
   logic [W-1:0] dec_w;
   logic [W-1:0] most_neg;

   assign sum_w    = {1'b0, b} + {1'b0, a};
   assign dif_w    = {1'b0, b} - {1'b0, a};
   assign dec_w    = b - W'(1);
   assign most_neg = {1'b1, {(W-1){1'b0}}};

   always_comb begin
      res = '0;
      cry = 1'b0;
      ovf = 1'b0;
      case (op)
         OPK_ADD: begin
            res = sum_w[W-1:0];
            cry = sum_w[W];
            ovf = (a[W-1] == b[W-1]) && (sum_w[W-1] != b[W-1]);
         end
         OPK_SUB, OPK_CMP: begin
            res = dif_w[W-1:0];
            cry = dif_w[W];
            ovf = (a[W-1] != b[W-1]) && (dif_w[W-1] != b[W-1]);
         end
         OPK_DEC: begin
            res = dec_w;
            ovf = (b == most_neg);
         end
         OPK_AND, OPK_TEST: res = b & a;
         OPK_OR:            res = b | a;
         OPK_XOR:           res = b ^ a;
         default:           res = '0;
      endcase
   end

   assign zro = (res == '0);
   assign sgn = res[W-1];
   assign par = ^res;

endmodule

// File: rtl/alu_cond_eval.sv
module alu_cond_eval
   import alu_flag_pkg::*;
(
   input  flag_s      flg,
   input  logic [3:0] sel,
   output logic       taken
);
   logic lt_s;
   logic be_u;

   assign lt_s = flg.sgn ^ flg.ovf;
   assign be_u = flg.cry | flg.zro;

   always_comb begin
      case (sel)
         CND_EQ:  taken = flg.zro;
         CND_NE:  taken = ~flg.zro;
         CND_LT:  taken = lt_s;
         CND_GE:  taken = ~lt_s;
         CND_LE:  taken = lt_s | flg.zro;
         CND_GT:  taken = ~(lt_s | flg.zro);
         CND_B:   taken = flg.cry;
         CND_AE:  taken = ~flg.cry;
         CND_BE:  taken = be_u;
         CND_A:   taken = ~be_u;
         default: taken = 1'b0;
      endcase
   end

endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
   import alu_flag_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            op_valid,
   input  logic [3:0]      op_kind,
   input  logic [1:0]      width_sel,
   input  logic [XLEN-1:0] src_a,
   input  logic [XLEN-1:0] dst_b,
   output logic [XLEN-1:0] result,
   output logic            result_we,
   output logic [4:0]      flags_out,
   input  logic [3:0]      cond_sel,
   output logic            cond_taken
);
   localparam int NUM_W = (XLEN == 64) ? 4 : (XLEN == 32) ? 3 : (XLEN == 16) ? 2 : 1;
   localparam logic [1:0] TOP_IDX = 2'(NUM_W - 1);

   if (!(XLEN == 8 || XLEN == 16 || XLEN == 32 || XLEN == 64)) begin : g_bad_xlen
      $error("alu_status_unit: XLEN must be 8, 16, 32 or 64");
   end

   logic [XLEN-1:0] lane_res [NUM_W];
   logic [NUM_W-1:0] lane_c, lane_o, lane_z, lane_s, lane_p;

   for (genvar k = 0; k < NUM_W; k++) begin : g_lane
      localparam int LW = 8 << k;
      logic [LW-1:0] r_k;
      alu_flag_lane #(.W(LW)) u_lane (
         .op  (op_kind),
         .a   (src_a[LW-1:0]),
         .b   (dst_b[LW-1:0]),
         .res (r_k),
         .cry (lane_c[k]),
         .ovf (lane_o[k]),
         .zro (lane_z[k]),
         .sgn (lane_s[k]),
         .par (lane_p[k])
      );
      assign lane_res[k] = XLEN'(r_k);
   end

   logic [1:0] sel_idx;
   assign sel_idx = (width_sel > TOP_IDX) ? TOP_IDX : width_sel;

   logic op_known;
   logic op_writes;
   assign op_known  = (op_kind <= OPK_CMP);
   assign op_writes = (op_kind <= OPK_XOR);

   assign result    = lane_res[sel_idx];
   assign result_we = op_valid && op_writes;

   flag_s flg_q, flg_d;

   always_comb begin
      flg_d.cry = (op_kind == OPK_DEC) ? flg_q.cry : lane_c[sel_idx];
      flg_d.ovf = lane_o[sel_idx];
      flg_d.zro = lane_z[sel_idx];
      flg_d.sgn = lane_s[sel_idx];
      flg_d.par = lane_p[sel_idx];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                    flg_q <= '0;
      else if (op_valid && op_known) flg_q <= flg_d;
   end

   assign flags_out = flg_q;

   alu_cond_eval u_cond (
      .flg   (flg_q),
      .sel   (cond_sel),
      .taken (cond_taken)
   );

   // R9: no defined operation, no flag change
   p_hold_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(op_valid && op_kind <= OPK_CMP) |=> $stable(flags_out))
      else $error("flags changed without an operation");

   // R7: logical classes leave carry and overflow cleared
   p_logic_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_kind >= OPK_AND && op_kind <= OPK_TEST) |=> (!flags_out[0] && !flags_out[4]))
      else $error("logical op left carry or overflow set");

   // R4: decrement keeps the earlier carry
   p_dec_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_kind == OPK_DEC) |=> (flags_out[0] == $past(flags_out[0])))
      else $error("decrement altered carry");

   // R5: a zero result can never carry a set sign bit
   p_zero_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
      flags_out[2] |-> !flags_out[3])
      else $error("zero and sign both set");

endmodule

// File: tb/alu_status_unit_test.sv
`timescale 1ns/1ps
module alu_status_unit_test;
   localparam int XLEN = 64;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            op_valid = 1'b0;
   logic [3:0]      op_kind = '0;
   logic [1:0]      width_sel = '0;
   logic [XLEN-1:0] src_a = '0;
   logic [XLEN-1:0] dst_b = '0;
   logic [XLEN-1:0] result;
   logic            result_we;
   logic [4:0]      flags_out;
   logic [3:0]      cond_sel = '0;
   logic            cond_taken;

   int n_chk = 0;
   int n_bad = 0;
   logic done = 1'b0;
   logic [4:0] exp_f = '0;

   always #10 clk = ~clk;

   alu_status_unit #(.XLEN(XLEN)) uut (
      .clk, .rst_n, .op_valid, .op_kind, .width_sel, .src_a, .dst_b,
      .result, .result_we, .flags_out, .cond_sel, .cond_taken
   );

   task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model(input logic [3:0] op, input logic [1:0] ws, input logic [63:0] a, input logic [63:0] b,
                        input logic [4:0] oldf, output logic [63:0] r, output logic we, output logic [4:0] f);
      int w;
      logic [63:0] m, msb, am, bm;
      logic [64:0] s;
      logic c, o;
      w = 8 << ws;
      m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
      msb = 64'd1 << (w - 1);
      am = a & m; bm = b & m; c = 1'b0; o = 1'b0; r = '0;
      case (op)
         4'd0: begin s = {1'b0, am} + {1'b0, bm}; r = s[63:0] & m; c = s[w];
                     o = ((am & msb) == (bm & msb)) && ((r & msb) != (bm & msb)); end
         4'd1, 4'd7: begin r = (bm - am) & m; c = bm < am;
                     o = ((am & msb) != (bm & msb)) && ((r & msb) != (bm & msb)); end
         4'd2: begin r = (bm - 64'd1) & m; c = oldf[0]; o = (bm == msb); end
         4'd3, 4'd6: r = am & bm;
         4'd4: r = am | bm;
         4'd5: r = am ^ bm;
         default: r = '0;
      endcase
      we = (op <= 4'd5);
      if (op <= 4'd7) f = {o, (r & msb) != 0, r == 0, ^r, c};
      else f = oldf;
   endtask

   function automatic logic cond_model(input logic [4:0] f, input logic [3:0] sel);
      logic c, p, z, s, o;
      {o, s, z, p, c} = f;
      case (sel)
         4'd0: return z;
         4'd1: return !z;
         4'd2: return s ^ o;
         4'd3: return !(s ^ o);
         4'd4: return (s ^ o) || z;
         4'd5: return !((s ^ o) || z);
         4'd6: return c;
         4'd7: return !c;
         4'd8: return c || z;
         4'd9: return !(c || z);
         default: return 1'b0;
      endcase
   endfunction

   task automatic do_op(input logic [3:0] op, input logic [1:0] ws, input logic [63:0] a,
                        input logic [63:0] b, input logic vld, input string tag);
      logic [63:0] r; logic we; logic [4:0] f;
      @(negedge clk);
      op_valid = vld; op_kind = op; width_sel = ws; src_a = a; dst_b = b;
      #2;
      model(op, ws, a, b, exp_f, r, we, f);
      if (!vld) begin we = 1'b0; f = exp_f; end
      chk(result_we == we, {tag, " write enable"}, 64'(result_we), 64'(we));
      if (we) chk(result == r, {tag, " result"}, result, r);
      @(negedge clk);
      op_valid = 1'b0;
      exp_f = f;
      chk(flags_out == exp_f, {tag, " flags"}, 64'(flags_out), 64'(exp_f));
   endtask

   task automatic sweep_conds(input string tag);
      for (int i = 0; i < 16; i++) begin
         cond_sel = 4'(i);
         #1;
         chk(cond_taken == cond_model(exp_f, 4'(i)), $sformatf("%s cond %0d", tag, i),
             64'(cond_taken), 64'(cond_model(exp_f, 4'(i))));
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(flags_out == 5'd0, "R9 reset flags", 64'(flags_out), 64'd0);
      sweep_conds("R10 reset");
   endtask

   task automatic t_add;
      do_op(4'd0, 2'd0, 64'h01, 64'hFF, 1'b1, "R4 R5 add carry to zero");
      do_op(4'd0, 2'd0, 64'h01, 64'h7F, 1'b1, "R6 add signed overflow");
      do_op(4'd0, 2'd3, 64'h1, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1, "R8 R6 add 64-bit overflow");
      do_op(4'd0, 2'd1, 64'hFFFF_0001, 64'h0000_FFFF, 1'b1, "R8 add 16-bit masks upper");
   endtask

   task automatic t_sub;
      do_op(4'd1, 2'd2, 64'd7, 64'd5, 1'b1, "R2 R4 sub dst minus src borrow");
      do_op(4'd1, 2'd2, 64'd5, 64'd7, 1'b1, "R2 sub order no borrow");
      do_op(4'd1, 2'd0, 64'h01, 64'h80, 1'b1, "R6 sub signed overflow");
   endtask

   task automatic t_cmp_test;
      do_op(4'd7, 2'd0, 64'h01, 64'h80, 1'b1, "R3 cmp no write");
      sweep_conds("R10 cmp signed vs unsigned");
      do_op(4'd7, 2'd1, 64'h1234, 64'h1234, 1'b1, "R3 cmp equal");
      sweep_conds("R11 cmp equal");
      do_op(4'd6, 2'd0, 64'hF0, 64'h0F, 1'b1, "R3 R7 test zero");
      do_op(4'd6, 2'd0, 64'hC1, 64'h81, 1'b1, "R3 R5 test sign parity");
   endtask

   task automatic t_logic;
      do_op(4'd0, 2'd0, 64'h01, 64'hFF, 1'b1, "R4 set carry");
      do_op(4'd4, 2'd0, 64'h03, 64'h80, 1'b1, "R7 or clears carry");
      do_op(4'd1, 2'd0, 64'h01, 64'h80, 1'b1, "R6 set overflow");
      do_op(4'd5, 2'd0, 64'hFF, 64'h0F, 1'b1, "R7 xor clears overflow");
      do_op(4'd3, 2'd2, 64'hFFFF_0000, 64'h8000_FFFF, 1'b1, "R7 and 32-bit");
   endtask

   task automatic t_dec_loop;
      logic [63:0] cnt;
      do_op(4'd0, 2'd0, 64'h01, 64'hFF, 1'b1, "R4 carry before loop");
      cnt = 64'd3;
      for (int i = 0; i < 3; i++) begin
         do_op(4'd2, 2'd2, 64'h0, cnt, 1'b1, "R4 R11 decrement");
         cnt = cnt - 64'd1;
         cond_sel = 4'd1; #1;
         chk(cond_taken == (cnt != 0), "R11 ne after decrement", 64'(cond_taken), 64'(cnt != 0));
      end
      do_op(4'd2, 2'd0, 64'h0, 64'h80, 1'b1, "R6 decrement most negative");
      do_op(4'd2, 2'd0, 64'h0, 64'h00, 1'b1, "R2 decrement wraps");
      sweep_conds("R10 after decrement");
   endtask

   task automatic t_hold;
      do_op(4'd7, 2'd0, 64'h05, 64'h03, 1'b1, "R9 known state");
      do_op(4'd0, 2'd0, 64'h00, 64'h00, 1'b0, "R9 no valid holds");
      do_op(4'd9, 2'd0, 64'h00, 64'h00, 1'b1, "R9 reserved op holds");
      do_op(4'd15, 2'd3, 64'h1, 64'h1, 1'b1, "R1 reserved op no write");
      do_op(4'd5, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, "R1 xor 64-bit write");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_add();
      t_sub();
      t_cmp_test();
      t_logic();
      t_dec_loop();
      t_hold();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule